// File: doc/BRIEF.md
# Floating-Point Control and Status Word

This block keeps the single control/status word of a floating-point unit and the logic that maintains it. The integer side reads and writes control registers through a 5-bit index with 32-bit data. Only one index holds storage. The other indexes read back as constants, and writes to them are discarded.

Every completed arithmetic operation presents its five exception indications. The block replaces the per-operation cause field with them and ORs them into the sticky flag field. If any raised cause has its enable set, the block withholds the operation's result writeback at once and raises a trap request on the following cycle. A software write to the word runs the same enabled-cause check. Eight condition-code bits can be set, cleared and tested one at a time through a 3-bit index. The two low bits drive the rounding mode.

Top module: `fpcsr_unit`

## Requirements
- R1: A read of index 31 returns the stored word combinationally, and a write becomes visible on the cycle after it. A read of index 0 (revision) or of any other index returns zero.
- R2: Only a write to index 31 changes the word. A write to any other index leaves the word unchanged and raises no trap.
- R3: Bits 24 and 22:18 are reserved. Written values are masked there, so those bits always read zero.
- R4: A write flagged as coming from integer register zero stores the value zero, whatever is on the data lines.
- R5: An operation writes its exceptions into cause bits 16:12 and clears cause bit 17 (unimplemented operation). The exception order is bit 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid. A cause bit left over from the previous operation is cleared.
- R6: Each exception of an operation also sets its flag in bits 6:2, in the same order. An operation never clears a flag.
- R7: An operation traps when an exception coincides with its enable in bits 11:7 (cause bit minus five). In that case `op_commit` is low in the same cycle and `trap_req` is high for the next cycle. An operation that does not trap has `op_commit` high.
- R8: After a write to index 31, `trap_req` is high on the next cycle exactly when a written cause bit in 16:12 has its enable set. Cause bit 17 alone never traps.
- R9: `round_mode` presents bits 1:0 of the word: 0 to nearest, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity.
- R10: Condition code 0 sits at bit 23 and codes 1 to 7 sit at bits 25 to 31. A code write stores `cc_wr_val` into the selected code. `cc_test_val` shows the code chosen by `cc_test_idx`.
- R11: A synchronous active-high reset clears the whole word and `trap_req`.
- R12: In a cycle with a write to index 31, the written value wins. The same-cycle operation update and code update are then dropped, although `op_commit` still follows R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr_en | input | 1 | Control-register write strobe |
| ctl_wr_idx | input | 5 | Control-register write index |
| ctl_wr_src_zero | input | 1 | Write source is integer register zero |
| ctl_wr_data | input | 32 | Write data |
| ctl_rd_idx | input | 5 | Control-register read index |
| ctl_rd_data | output | 32 | Read data |
| op_valid | input | 1 | An arithmetic operation completes this cycle |
| op_exc | input | 5 | Exceptions of that operation |
| op_commit | output | 1 | Result writeback allowed |
| trap_req | output | 1 | Trap request, one cycle after the trigger |
| cc_wr_en | input | 1 | Condition-code write strobe |
| cc_wr_idx | input | 3 | Condition code to write |
| cc_wr_val | input | 1 | Value to store |
| cc_test_idx | input | 3 | Condition code to test |
| cc_test_val | output | 1 | Selected condition code |
| round_mode | output | 2 | Current rounding mode |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 5-bit index, storage at index 31, revision index 0 reading zero, and eight condition codes. With eight codes, both the lone bit-23 code and the upper run at 31:25 are exercised, including the highest code at bit 31. Index 31 being the top of the 5-bit space puts the full-mask write and the writes to other indexes within reach.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

   localparam int CSR_W      = 32;
   localparam int EXC_N      = 5;
   localparam int RM_LSB     = 0;
   localparam int RM_W       = 2;
   localparam int FLAG_LSB   = 2;
   localparam int EN_LSB     = FLAG_LSB + EXC_N;
   localparam int CAUSE_LSB  = EN_LSB + EXC_N;
   localparam int UNIMPL_BIT = CAUSE_LSB + EXC_N;
   localparam int CC0_BIT    = 23;
   localparam int CCHI_LSB   = 25;
   localparam int CC_MAX     = 8;

   typedef enum logic [RM_W-1:0] {
      RM_NEAREST = 2'd0,
      RM_ZERO    = 2'd1,
      RM_UP      = 2'd2,
      RM_DOWN    = 2'd3
   } rmode_e;

   function automatic int cc_pos(int k);
      return (k == 0) ? CC0_BIT : (CCHI_LSB + k - 1);
   endfunction

   function automatic logic [CSR_W-1:0] wr_mask_f(int n_cc);
      logic [CSR_W-1:0] m;
      m = '0;
      for (int b = RM_LSB; b <= UNIMPL_BIT; b++) m[b] = 1'b1;
      for (int k = 0; k < n_cc; k++) m[cc_pos(k)] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/fpcsr_excpt.sv
module fpcsr_excpt
   import fpcsr_pkg::*;
#(
   parameter int W = CSR_W,
   parameter int N = EXC_N
) (
   input  logic [W-1:0] word_in,
   input  logic         op_valid,
   input  logic [N-1:0] op_exc,
   output logic [W-1:0] word_out,
   output logic         op_trap
);

   logic [N-1:0] en_cur;
   logic [N-1:0] flag_cur;

   assign en_cur   = word_in[EN_LSB +: N];
   assign flag_cur = word_in[FLAG_LSB +: N];
   assign op_trap  = op_valid & (|(op_exc & en_cur));

   always_comb begin
      word_out = word_in;
      if (op_valid) begin
         word_out[CAUSE_LSB +: N] = op_exc;
         word_out[UNIMPL_BIT]     = 1'b0;
         word_out[FLAG_LSB +: N]  = flag_cur | op_exc;
      end
   end

endmodule

// File: rtl/fpcsr_ccbank.sv
module fpcsr_ccbank
   import fpcsr_pkg::*;
#(
   parameter int W        = CSR_W,
   parameter int NUM_CC   = 8,
   parameter int CC_IDX_W = $clog2(NUM_CC)
) (
   input  logic [W-1:0]        word_in,
   input  logic                wr_en,
   input  logic [CC_IDX_W-1:0] wr_idx,
   input  logic                wr_val,
   input  logic [CC_IDX_W-1:0] test_idx,
   output logic [W-1:0]        word_out,
   output logic                test_val
);

   localparam int SLOTS = 1 << CC_IDX_W;

   logic [SLOTS-1:0] cc_vec;
   logic [SLOTS-1:0] cc_next;

   for (genvar k = 0; k < SLOTS; k++) begin : g_cc
      if (k < NUM_CC) begin : g_live
         assign cc_vec[k]  = word_in[cc_pos(k)];
         assign cc_next[k] = (wr_en && (wr_idx == CC_IDX_W'(k))) ? wr_val : cc_vec[k];
      end else begin : g_pad
         assign cc_vec[k]  = 1'b0;
         assign cc_next[k] = 1'b0;
      end
   end

   always_comb begin
      word_out = word_in;
      for (int k = 0; k < NUM_CC; k++) word_out[cc_pos(k)] = cc_next[k];
   end

   assign test_val = cc_vec[test_idx];

endmodule

// File: rtl/fpcsr_rdmux.sv
module fpcsr_rdmux #(
   parameter int               W         = 32,
   parameter int               IDX_W     = 5,
   parameter int               CSR_IDX   = 31,
   parameter int               REV_IDX   = 0,
   parameter logic [W-1:0]     REV_VALUE = '0
) (
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [W-1:0]     word,
   output logic [W-1:0]     rd_data
);

   always_comb begin
      if (rd_idx == IDX_W'(CSR_IDX))      rd_data = word;
      else if (rd_idx == IDX_W'(REV_IDX)) rd_data = REV_VALUE;
      else                                rd_data = '0;
   end

endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
   import fpcsr_pkg::*;
#(
   parameter int W         = 32,
   parameter int IDX_W     = 5,
   parameter int CSR_IDX   = 31,
   parameter int REV_IDX   = 0,
   parameter int NUM_CC    = 8,
   parameter int CC_IDX_W  = $clog2(NUM_CC)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ctl_wr_en,
   input  logic [IDX_W-1:0]    ctl_wr_idx,
   input  logic                ctl_wr_src_zero,
   input  logic [W-1:0]        ctl_wr_data,
   input  logic [IDX_W-1:0]    ctl_rd_idx,
   output logic [W-1:0]        ctl_rd_data,
   input  logic                op_valid,
   input  logic [EXC_N-1:0]    op_exc,
   output logic                op_commit,
   output logic                trap_req,
   input  logic                cc_wr_en,
   input  logic [CC_IDX_W-1:0] cc_wr_idx,
   input  logic                cc_wr_val,
   input  logic [CC_IDX_W-1:0] cc_test_idx,
   output logic                cc_test_val,
   output logic [RM_W-1:0]     round_mode
);

   localparam logic [W-1:0] WMASK = wr_mask_f(NUM_CC);

   if (W != CSR_W) begin : g_bad_width
      $error("fpcsr_unit: word width must equal the fixed field layout width");
   end
   if (CSR_IDX >= (1 << IDX_W) || REV_IDX >= (1 << IDX_W) || CSR_IDX == REV_IDX) begin : g_bad_idx
      $error("fpcsr_unit: register indexes out of range or overlapping");
   end
   if (NUM_CC < 2 || NUM_CC > CC_MAX) begin : g_bad_cc
      $error("fpcsr_unit: condition-code count out of range");
   end

   logic [W-1:0] csr_q;
   logic [W-1:0] csr_d;
   logic [W-1:0] word_op;
   logic [W-1:0] word_cc;
   logic [W-1:0] wr_masked;
   logic         wr_hit;
   logic         op_trap;
   logic         wr_trap;
   logic         trap_d;

   assign wr_hit    = ctl_wr_en && (ctl_wr_idx == IDX_W'(CSR_IDX));
   assign wr_masked = (ctl_wr_src_zero ? '0 : ctl_wr_data) & WMASK;
   assign wr_trap   = |(wr_masked[CAUSE_LSB +: EXC_N] & wr_masked[EN_LSB +: EXC_N]);

   fpcsr_excpt #(.W(W), .N(EXC_N)) u_excpt (
      .word_in  (csr_q),
      .op_valid (op_valid),
      .op_exc   (op_exc),
      .word_out (word_op),
      .op_trap  (op_trap)
   );

   fpcsr_ccbank #(.W(W), .NUM_CC(NUM_CC), .CC_IDX_W(CC_IDX_W)) u_cc (
      .word_in  (word_op),
      .wr_en    (cc_wr_en),
      .wr_idx   (cc_wr_idx),
      .wr_val   (cc_wr_val),
      .test_idx (cc_test_idx),
      .word_out (word_cc),
      .test_val (cc_test_val)
   );

   fpcsr_rdmux #(
      .W(W), .IDX_W(IDX_W), .CSR_IDX(CSR_IDX), .REV_IDX(REV_IDX), .REV_VALUE('0)
   ) u_rd (
      .rd_idx  (ctl_rd_idx),
      .word    (csr_q),
      .rd_data (ctl_rd_data)
   );

   assign csr_d = wr_hit ? wr_masked : word_cc;
   assign trap_d = wr_hit ? wr_trap : op_trap;

   always_ff @(posedge clk) begin
      if (rst) begin
         csr_q    <= '0;
         trap_req <= 1'b0;
      end else begin
         csr_q    <= csr_d;
         trap_req <= trap_d;
      end
   end

   assign op_commit  = op_valid & ~op_trap;
   assign round_mode = csr_q[RM_LSB +: RM_W];

endmodule

// File: rtl/fpcsr_unit_chk.sv
module fpcsr_unit_chk
   import fpcsr_pkg::*;
#(
   parameter int W       = 32,
   parameter int IDX_W   = 5,
   parameter int CSR_IDX = 31,
   parameter int NUM_CC  = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             ctl_wr_en,
   input logic [IDX_W-1:0] ctl_wr_idx,
   input logic [IDX_W-1:0] ctl_rd_idx,
   input logic [W-1:0]     ctl_rd_data,
   input logic             op_valid,
   input logic [EXC_N-1:0] op_exc,
   input logic             op_commit,
   input logic             trap_req,
   input logic [W-1:0]     csr_q
);

   localparam logic [W-1:0] WMASK = wr_mask_f(NUM_CC);

   logic wr_hit;
   assign wr_hit = ctl_wr_en && (ctl_wr_idx == IDX_W'(CSR_IDX));

   p_other_idx_zero_r1: assert property (@(posedge clk) disable iff (rst)
      (ctl_rd_idx != IDX_W'(CSR_IDX)) |-> (ctl_rd_data == '0));

   p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
      ((csr_q & ~WMASK) == '0));

   p_cause_replaced_r5: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !wr_hit) |=> (csr_q[CAUSE_LSB +: EXC_N] == $past(op_exc)) && !csr_q[UNIMPL_BIT]);

   p_flags_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      !wr_hit |=> ((csr_q[FLAG_LSB +: EXC_N] & $past(csr_q[FLAG_LSB +: EXC_N]))
                   == $past(csr_q[FLAG_LSB +: EXC_N])));

   p_commit_blocked_r7: assert property (@(posedge clk) disable iff (rst)
      (op_valid && (|(op_exc & csr_q[EN_LSB +: EXC_N]))) |-> !op_commit);

   p_trap_after_op_r7: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !wr_hit && (|(op_exc & csr_q[EN_LSB +: EXC_N]))) |=> trap_req);

   p_trap_has_source_r8: assert property (@(posedge clk) disable iff (rst)
      trap_req |-> $past(op_valid || wr_hit));

endmodule

bind fpcsr_unit fpcsr_unit_chk #(
   .W(W), .IDX_W(IDX_W), .CSR_IDX(CSR_IDX), .NUM_CC(NUM_CC)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .ctl_wr_en   (ctl_wr_en),
   .ctl_wr_idx  (ctl_wr_idx),
   .ctl_rd_idx  (ctl_rd_idx),
   .ctl_rd_data (ctl_rd_data),
   .op_valid    (op_valid),
   .op_exc      (op_exc),
   .op_commit   (op_commit),
   .trap_req    (trap_req),
   .csr_q       (csr_q)
);

// File: tb/fpcsr_unit_tb_top.sv
`timescale 1ns/1ps
module fpcsr_unit_tb_top;

   localparam logic [31:0] WMASK = 32'hFE83_FFFF;

   typedef struct packed {
      logic        wr;
      logic        zero;
      logic [4:0]  idx;
      logic [31:0] data;
      logic        opv;
      logic [4:0]  exc;
      logic        ccw;
      logic [2:0]  cci;
      logic        ccv;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{1'b1,1'b0,5'd31,32'hFFFF_FFFF,1'b0,5'b00000,1'b0,3'd0,1'b0}, // R3 R8 full write
      '{1'b1,1'b0,5'd31,32'h0000_0003,1'b0,5'b00000,1'b0,3'd0,1'b0}, // R9 mode 3
      '{1'b0,1'b0,5'd0, 32'h0,        1'b1,5'b00001,1'b0,3'd0,1'b0}, // R5 R6 inexact
      '{1'b0,1'b0,5'd0, 32'h0,        1'b1,5'b10100,1'b0,3'd0,1'b0}, // R5 replace
      '{1'b0,1'b0,5'd0, 32'h0,        1'b1,5'b00000,1'b0,3'd0,1'b0}, // R6 flags stay
      '{1'b1,1'b0,5'd31,32'h0000_0801,1'b0,5'b00000,1'b0,3'd0,1'b0}, // enable invalid, R9 mode 1
      '{1'b0,1'b0,5'd0, 32'h0,        1'b1,5'b10000,1'b0,3'd0,1'b0}, // R7 trap
      '{1'b0,1'b0,5'd0, 32'h0,        1'b1,5'b00010,1'b0,3'd0,1'b0}, // R7 no trap
      '{1'b0,1'b0,5'd0, 32'h0,        1'b0,5'b00000,1'b1,3'd0,1'b1}, // R10 cc0 bit 23
      '{1'b0,1'b0,5'd0, 32'h0,        1'b0,5'b00000,1'b1,3'd7,1'b1}, // R10 cc7 bit 31
      '{1'b0,1'b0,5'd0, 32'h0,        1'b1,5'b00001,1'b1,3'd3,1'b1}, // R10 cc3 with op
      '{1'b0,1'b0,5'd0, 32'h0,        1'b0,5'b00000,1'b1,3'd0,1'b0}, // R10 clear cc0
      '{1'b1,1'b0,5'd5, 32'hFFFF_FFFF,1'b0,5'b00000,1'b0,3'd0,1'b0}, // R2 other index
      '{1'b1,1'b1,5'd31,32'hFFFF_FFFF,1'b0,5'b00000,1'b0,3'd0,1'b0}, // R4 zero source
      '{1'b1,1'b0,5'd31,32'h0001_0800,1'b0,5'b00000,1'b0,3'd0,1'b0}, // R8 pending enabled cause
      '{1'b1,1'b0,5'd31,32'h0002_0000,1'b1,5'b00100,1'b0,3'd0,1'b0}  // R12 write wins, R8 bit17 alone
   };

   logic        clk = 1'b0;
   logic        rst;
   logic        ctl_wr_en, ctl_wr_src_zero, op_valid, cc_wr_en, cc_wr_val;
   logic [4:0]  ctl_wr_idx, ctl_rd_idx, op_exc;
   logic [31:0] ctl_wr_data, ctl_rd_data;
   logic [2:0]  cc_wr_idx, cc_test_idx;
   logic        op_commit, trap_req, cc_test_val;
   logic [1:0]  round_mode;

   int   n_chk = 0;
   int   n_bad = 0;
   logic [31:0] model;
   logic        done = 1'b0;

   always #2.5 clk = ~clk;

   fpcsr_unit dut_i (
      .clk(clk), .rst(rst),
      .ctl_wr_en(ctl_wr_en), .ctl_wr_idx(ctl_wr_idx), .ctl_wr_src_zero(ctl_wr_src_zero),
      .ctl_wr_data(ctl_wr_data), .ctl_rd_idx(ctl_rd_idx), .ctl_rd_data(ctl_rd_data),
      .op_valid(op_valid), .op_exc(op_exc), .op_commit(op_commit), .trap_req(trap_req),
      .cc_wr_en(cc_wr_en), .cc_wr_idx(cc_wr_idx), .cc_wr_val(cc_wr_val),
      .cc_test_idx(cc_test_idx), .cc_test_val(cc_test_val), .round_mode(round_mode)
   );

   function automatic int ccpos(logic [2:0] k);
      return (k == 3'd0) ? 23 : 24 + int'(k);
   endfunction

   function automatic logic [32:0] model_next(logic [31:0] w, vec_t v);
      logic [31:0] n;
      logic        t;
      n = w;
      t = 1'b0;
      if (v.wr && v.idx == 5'd31) begin
         n = (v.zero ? 32'h0 : v.data) & WMASK;
         t = |(n[16:12] & n[11:7]);
      end else begin
         if (v.opv) begin
            n[17]    = 1'b0;
            n[16:12] = v.exc;
            n[6:2]   = n[6:2] | v.exc;
            t        = |(v.exc & w[11:7]);
         end
         if (v.ccw) n[ccpos(v.cci)] = v.ccv;
      end
      return {t, n};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      ctl_wr_en = 0; ctl_wr_src_zero = 0; ctl_wr_idx = 0; ctl_wr_data = 0;
      op_valid = 0; op_exc = 0; cc_wr_en = 0; cc_wr_idx = 0; cc_wr_val = 0;
   endtask

   task automatic step(vec_t v);
      logic [32:0] nx;
      @(negedge clk);
      ctl_wr_en = v.wr; ctl_wr_src_zero = v.zero; ctl_wr_idx = v.idx; ctl_wr_data = v.data;
      op_valid = v.opv; op_exc = v.exc; cc_wr_en = v.ccw; cc_wr_idx = v.cci; cc_wr_val = v.ccv;
      cc_test_idx = v.cci; ctl_rd_idx = 5'd31;
      #1;
      chk("R7 op_commit", 32'(op_commit), 32'(v.opv & ~(|(v.exc & model[11:7]))));
      nx = model_next(model, v);
      @(posedge clk);
      #1;
      model = nx[31:0];
      chk("R1/R5/R6 word", ctl_rd_data, model);
      chk("R7/R8 trap_req", 32'(trap_req), 32'(nx[32]));
      chk("R9 round_mode", 32'(round_mode), 32'(model[1:0]));
      chk("R10 cc_test_val", 32'(cc_test_val), 32'(model[ccpos(v.cci)]));
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle();
      ctl_rd_idx = 5'd31; cc_test_idx = 0;
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      model = 32'h0;
      // R11 reset state
      chk("R11 word after reset", ctl_rd_data, 32'h0);
      chk("R11 trap after reset", 32'(trap_req), 32'h0);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i]);
         @(negedge clk);
         idle();
      end

      // R1 revision and unused indexes read zero while the word is nonzero
      @(negedge clk);
      ctl_rd_idx = 5'd0;
      #1 chk("R1 revision index", ctl_rd_data, 32'h0);
      ctl_rd_idx = 5'd9;
      #1 chk("R1 other index", ctl_rd_data, 32'h0);
      ctl_rd_idx = 5'd31;
      #1 chk("R1 word index", ctl_rd_data, model);
      // R8 no trap one idle cycle later
      chk("R8 trap pulse ends", 32'(trap_req), 32'h0);

      // R11 reset mid-run clears everything
      rst = 1'b1;
      @(posedge clk);
      #1;
      rst = 1'b0;
      model = 32'h0;
      chk("R11 word after mid reset", ctl_rd_data, 32'h0);
      chk("R11 trap after mid reset", 32'(trap_req), 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule